// File: doc/BRIEF.md
# Two-Lane FP64 Truncate-to-Integral Unit

This execution unit accepts one request at a time naming a source and a destination entry in a 64-entry, 128-bit vector register file. The source entry holds two IEEE-754 double-precision values. Each value goes through its own rounding path, which rounds toward zero. The integral result stays in double-precision format. Both results are written together into the destination entry.

Signalling NaNs are quieted, and every one seen sets a sticky status bit. If the trap enable is set and either lane carries a signalling NaN, the destination write is dropped for both lanes. The sticky bit is still updated in that case.

If the facility-enable input is low, the request completes without executing and reports a facility-unavailable exception. A second write port and a second read port let the surrounding datapath load and inspect register contents.

Top module: `vtrunc_unit`

## Requirements
- R1: After reset, `done_o`, `trap_o`, `fac_unavail_o` and `sticky_snan_o` are all 0.
- R2: The source index is `{src_hi_i, src_lo_i}` and the destination index is `{dst_hi_i, dst_lo_i}`. The 1-bit field is the MSB of the 6-bit index.
- R3: For a finite input with biased exponent from 1023 to 1074, the result keeps the sign and exponent and clears every fraction bit below the binary point. Truncation never increases the magnitude.
- R4: A nonzero input whose magnitude is below 1.0 (biased exponent below 1023, subnormals included) gives a zero with the input's sign.
- R5: The following inputs are returned bit-for-bit unchanged:
  - inputs with biased exponent 1075 or more;
  - infinities;
  - quiet NaNs (exponent all ones, fraction bit 51 set);
  - zeros.
- R6: A signalling NaN (exponent all ones, nonzero fraction, fraction bit 51 clear) produces the same word with bit 51 set. It also sets `sticky_snan_o`, which stays 1 until reset.
- R7: If `trap_en_i` is 1 and either lane holds a signalling NaN, neither lane of the destination is written. `trap_o` pulses with `done_o`, and `sticky_snan_o` is set.
- R8: If `trap_en_i` is 0, a signalling-NaN result is written normally and `trap_o` stays 0.
- R9: If `fac_en_i` is 0, the following happen:
  - `fac_unavail_o` pulses with `done_o`;
  - the destination is not written;
  - `sticky_snan_o` is unchanged.
- R10: `done_o` is 1 for exactly one cycle, two clock edges after the edge that samples `issue_valid_i`. The write is then visible through the read port.
- R11: Lane 0 is bits [63:0] and lane 1 is bits [127:64]. Each lane's result depends only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid_i | input | 1 | Start one operation |
| src_lo_i | input | 5 | Low bits of source index |
| src_hi_i | input | 1 | MSB of source index |
| dst_lo_i | input | 5 | Low bits of destination index |
| dst_hi_i | input | 1 | MSB of destination index |
| fac_en_i | input | 1 | Vector facility enabled |
| trap_en_i | input | 1 | Invalid-SNaN trap enable |
| ext_we_i | input | 1 | External register-file write enable |
| ext_widx_i | input | 6 | External write index |
| ext_wdata_i | input | 128 | External write data |
| ext_ridx_i | input | 6 | External read index |
| ext_rdata_o | output | 128 | External read data, one cycle after index |
| done_o | output | 1 | Operation completed |
| fac_unavail_o | output | 1 | Facility-unavailable exception |
| trap_o | output | 1 | Trap-enabled SNaN exception, write suppressed |
| sticky_snan_o | output | 1 | Sticky invalid-SNaN status |

## Verification
The unit is exercised with the following input patterns, and each one separates a different branch of the per-lane decision:
- Ordinary fractional values of both signs, including one just below 2^52, check mask generation.
- Sub-unity values and a subnormal check signed-zero production.
- Large values, infinities, quiet NaNs, zeros and exact integers must come back untouched.
- Signalling NaNs in one lane, with the trap enable off and then on, separate quieting, sticky update and whole-write suppression.
- A disabled facility shows that neither the register file nor the status changes.

Different lane contents and source/destination indices whose MSB differs show the lane ordering and the index formation.

// File: rtl/vtrunc_pkg.sv
package vtrunc_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp64_t;
endpackage

// File: rtl/vtrunc_lane.sv
module vtrunc_lane
  import vtrunc_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output logic [FP_W-1:0] res_o,
  output logic            snan_o
);
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_BIG = EXP_W'(BIAS + FRAC_W);

  fp64_t             f, r;
  logic              special;
  logic [5:0]        shamt;
  logic [FRAC_W-1:0] keep;

  always_comb begin
    f       = fp64_t'(op_i);
    special = (f.exp == '1);
    snan_o  = special && (f.frac != '0) && !f.frac[FRAC_W-1];
    shamt   = 6'(f.exp - EXP_ONE);
    keep    = ~({FRAC_W{1'b1}} >> shamt);
    r       = f;
    if (snan_o) begin
      r.frac[FRAC_W-1] = 1'b1;
    end else if (special) begin
      r = f;
    end else if (f.exp < EXP_ONE) begin
      r.exp  = '0;
      r.frac = '0;
    end else if (f.exp < EXP_BIG) begin
      r.frac = f.frac & keep;
    end
    res_o = FP_W'(r);
  end

  // truncation never grows the magnitude, quieting aside
  always_comb begin
    if (!$isunknown(op_i)) begin
      assert_no_growth_R3: assert (snan_o || (res_o[FP_W-2:0] <= op_i[FP_W-2:0]));
    end
  end
endmodule

// File: rtl/vtrunc_rf.sv
module vtrunc_rf #(
  parameter int AW = 6,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    ra_data_o <= mem[ra_idx_i];
    rb_data_o <= mem[rb_idx_i];
  end
endmodule

// File: rtl/vtrunc_unit.sv
module vtrunc_unit
  import vtrunc_pkg::*;
#(
  parameter int LANES = 2,
  parameter int FLD_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_valid_i,
  input  logic [FLD_W-1:0]        src_lo_i,
  input  logic                    src_hi_i,
  input  logic [FLD_W-1:0]        dst_lo_i,
  input  logic                    dst_hi_i,
  input  logic                    fac_en_i,
  input  logic                    trap_en_i,
  input  logic                    ext_we_i,
  input  logic [FLD_W:0]          ext_widx_i,
  input  logic [LANES*FP_W-1:0]   ext_wdata_i,
  input  logic [FLD_W:0]          ext_ridx_i,
  output logic [LANES*FP_W-1:0]   ext_rdata_o,
  output logic                    done_o,
  output logic                    fac_unavail_o,
  output logic                    trap_o,
  output logic                    sticky_snan_o
);
  localparam int AW    = FLD_W + 1;
  localparam int VEC_W = LANES * FP_W;

  logic             s1_v, s1_fac, s1_ve;
  logic [AW-1:0]    s1_dst;
  logic [VEC_W-1:0] src_vec, res_vec;
  logic [LANES-1:0] lane_snan;
  logic             any_snan, s1_trap, unit_we;
  logic             rf_we;
  logic [AW-1:0]    rf_widx;
  logic [VEC_W-1:0] rf_wdata;

  // stage 0 -> 1: capture request, register file read in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_fac <= 1'b0;
      s1_ve  <= 1'b0;
      s1_dst <= '0;
    end else begin
      s1_v   <= issue_valid_i;
      s1_fac <= fac_en_i;
      s1_ve  <= trap_en_i;
      s1_dst <= {dst_hi_i, dst_lo_i};
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vtrunc_lane u_lane (
      .op_i   (src_vec[g*FP_W +: FP_W]),
      .res_o  (res_vec[g*FP_W +: FP_W]),
      .snan_o (lane_snan[g])
    );
  end

  assign any_snan = |lane_snan;
  assign s1_trap  = s1_fac & s1_ve & any_snan;
  assign unit_we  = s1_v & s1_fac & ~s1_trap;

  // the unit's own writeback takes the port over an external write
  assign rf_we    = unit_we | ext_we_i;
  assign rf_widx  = unit_we ? s1_dst  : ext_widx_i;
  assign rf_wdata = unit_we ? res_vec : ext_wdata_i;

  vtrunc_rf #(.AW(AW), .DW(VEC_W)) u_rf (
    .clk       (clk),
    .we_i      (rf_we),
    .widx_i    (rf_widx),
    .wdata_i   (rf_wdata),
    .ra_idx_i  ({src_hi_i, src_lo_i}),
    .ra_data_o (src_vec),
    .rb_idx_i  (ext_ridx_i),
    .rb_data_o (ext_rdata_o)
  );

  // stage 1 -> 2: status and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o        <= 1'b0;
      fac_unavail_o <= 1'b0;
      trap_o        <= 1'b0;
      sticky_snan_o <= 1'b0;
    end else begin
      done_o        <= s1_v;
      fac_unavail_o <= s1_v & ~s1_fac;
      trap_o        <= s1_v & s1_trap;
      if (s1_v && s1_fac && any_snan) sticky_snan_o <= 1'b1;
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    issue_valid_i |=> ##1 done_o);
  assert_flags_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    (trap_o || fac_unavail_o) |-> done_o);
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    sticky_snan_o |=> sticky_snan_o);
  assert_trap_sets_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> sticky_snan_o);
  assert_fac_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    fac_unavail_o |-> (!trap_o && (sticky_snan_o == $past(sticky_snan_o))));
endmodule

// File: tb/tb_vtrunc_unit.sv
module tb_vtrunc_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_valid_i = 1'b0;
  logic [4:0]   src_lo_i = '0, dst_lo_i = '0;
  logic         src_hi_i = 1'b0, dst_hi_i = 1'b0;
  logic         fac_en_i = 1'b1, trap_en_i = 1'b0;
  logic         ext_we_i = 1'b0;
  logic [5:0]   ext_widx_i = '0, ext_ridx_i = '0;
  logic [127:0] ext_wdata_i = '0;
  logic [127:0] ext_rdata_o;
  logic         done_o, fac_unavail_o, trap_o, sticky_snan_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtrunc_unit dut (
    .clk(clk), .rst(rst), .issue_valid_i(issue_valid_i),
    .src_lo_i(src_lo_i), .src_hi_i(src_hi_i),
    .dst_lo_i(dst_lo_i), .dst_hi_i(dst_hi_i),
    .fac_en_i(fac_en_i), .trap_en_i(trap_en_i),
    .ext_we_i(ext_we_i), .ext_widx_i(ext_widx_i), .ext_wdata_i(ext_wdata_i),
    .ext_ridx_i(ext_ridx_i), .ext_rdata_o(ext_rdata_o),
    .done_o(done_o), .fac_unavail_o(fac_unavail_o), .trap_o(trap_o),
    .sticky_snan_o(sticky_snan_o)
  );

  localparam logic [63:0] P2_75   = 64'h4006000000000000;
  localparam logic [63:0] P2_0    = 64'h4000000000000000;
  localparam logic [63:0] M3_5    = 64'hC00C000000000000;
  localparam logic [63:0] M3_0    = 64'hC008000000000000;
  localparam logic [63:0] P0_75   = 64'h3FE8000000000000;
  localparam logic [63:0] M0_5    = 64'hBFE0000000000000;
  localparam logic [63:0] PZERO   = 64'h0000000000000000;
  localparam logic [63:0] NZERO   = 64'h8000000000000000;
  localparam logic [63:0] NEAR52  = 64'h432FFFFFFFFFFFFF;
  localparam logic [63:0] NEAR52T = 64'h432FFFFFFFFFFFFE;
  localparam logic [63:0] P123F   = 64'h405EDD2F1A9FBE77;
  localparam logic [63:0] P123    = 64'h405EC00000000000;
  localparam logic [63:0] P2_53   = 64'h4340000000000000;
  localparam logic [63:0] PINF    = 64'h7FF0000000000000;
  localparam logic [63:0] QNAN    = 64'h7FF8000000000001;
  localparam logic [63:0] P1_0    = 64'h3FF0000000000000;
  localparam logic [63:0] P1_5    = 64'h3FF8000000000000;
  localparam logic [63:0] SNAN    = 64'h7FF0000000000005;
  localparam logic [63:0] SNANQ   = 64'h7FF8000000000005;
  localparam logic [63:0] NSNAN   = 64'hFFF4000000000000;
  localparam logic [63:0] P2_5    = 64'h4004000000000000;
  localparam logic [63:0] SUBN    = 64'h0000000000000001;
  localparam logic [127:0] SENT   = {2{64'hDEADBEEFCAFEF00D}};

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic load(input logic [5:0] idx, input logic [127:0] val);
    @(negedge clk);
    ext_we_i = 1'b1; ext_widx_i = idx; ext_wdata_i = val;
    @(negedge clk);
    ext_we_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] idx, output logic [127:0] val);
    ext_ridx_i = idx;
    @(negedge clk);
    val = ext_rdata_o;
  endtask

  // issue one operation; returns flags sampled in the done cycle
  task automatic run_op(input logic [5:0] src, input logic [5:0] dst,
                        input logic fac, input logic ve,
                        output logic trp, output logic fu);
    @(negedge clk);
    src_hi_i = src[5]; src_lo_i = src[4:0];
    dst_hi_i = dst[5]; dst_lo_i = dst[4:0];
    fac_en_i = fac; trap_en_i = ve; issue_valid_i = 1'b1;
    @(negedge clk);
    issue_valid_i = 1'b0;
    check("R10 done not yet", {127'b0, done_o}, 128'd0);
    @(negedge clk);
    check("R10 done pulse", {127'b0, done_o}, 128'd1);
    trp = trap_o; fu = fac_unavail_o;
  endtask

  task automatic t_reset();
    check("R1 done", {127'b0, done_o}, 128'd0);
    check("R1 trap", {127'b0, trap_o}, 128'd0);
    check("R1 fac", {127'b0, fac_unavail_o}, 128'd0);
    check("R1 sticky", {127'b0, sticky_snan_o}, 128'd0);
  endtask

  task automatic t_normal();
    logic t, f; logic [127:0] v;
    load(6'd3, {M3_5, P2_75});
    run_op(6'd3, 6'd37, 1'b1, 1'b0, t, f);
    check("R3 no trap", {127'b0, t}, 128'd0);
    peek(6'd37, v);
    check("R3 R11 R2 fractional lanes", v, {M3_0, P2_0});
    @(negedge clk);
    check("R10 single-cycle done", {127'b0, done_o}, 128'd0);
  endtask

  task automatic t_small();
    logic t, f; logic [127:0] v;
    load(6'd4, {M0_5, P0_75});
    run_op(6'd4, 6'd6, 1'b1, 1'b0, t, f);
    peek(6'd6, v);
    check("R4 signed zeros", v, {NZERO, PZERO});
    load(6'd4, {SUBN, P1_5});
    run_op(6'd4, 6'd6, 1'b1, 1'b0, t, f);
    peek(6'd6, v);
    check("R4 subnormal to zero, R3 1.5", v, {PZERO, P1_0});
  endtask

  task automatic t_edge();
    logic t, f; logic [127:0] v;
    load(6'd7, {NEAR52, P123F});
    run_op(6'd7, 6'd8, 1'b1, 1'b0, t, f);
    peek(6'd8, v);
    check("R3 mask edges", v, {NEAR52T, P123});
  endtask

  task automatic t_pass();
    logic t, f; logic [127:0] v;
    load(6'd9, {P2_53, PINF});
    run_op(6'd9, 6'd10, 1'b1, 1'b0, t, f);
    peek(6'd10, v);
    check("R5 large and inf", v, {P2_53, PINF});
    load(6'd9, {QNAN, NZERO});
    run_op(6'd9, 6'd10, 1'b1, 1'b1, t, f);
    peek(6'd10, v);
    check("R5 qnan and zero", v, {QNAN, NZERO});
    check("R5 qnan no trap", {127'b0, t}, 128'd0);
    check("R5 qnan no sticky", {127'b0, sticky_snan_o}, 128'd0);
  endtask

  task automatic t_snan_untrapped();
    logic t, f; logic [127:0] v;
    load(6'd11, {P1_5, SNAN});
    run_op(6'd11, 6'd12, 1'b1, 1'b0, t, f);
    check("R8 no trap", {127'b0, t}, 128'd0);
    check("R6 sticky set", {127'b0, sticky_snan_o}, 128'd1);
    peek(6'd12, v);
    check("R6 R8 quieted and written", v, {P1_0, SNANQ});
    load(6'd11, {P2_75, P2_75});
    run_op(6'd11, 6'd12, 1'b1, 1'b0, t, f);
    check("R6 sticky holds", {127'b0, sticky_snan_o}, 128'd1);
  endtask

  task automatic t_snan_trapped();
    logic t, f; logic [127:0] v;
    do_reset();
    load(6'd14, SENT);
    load(6'd13, {NSNAN, P2_5});
    run_op(6'd13, 6'd14, 1'b1, 1'b1, t, f);
    check("R7 trap pulse", {127'b0, t}, 128'd1);
    check("R7 sticky set", {127'b0, sticky_snan_o}, 128'd1);
    peek(6'd14, v);
    check("R7 no lane written", v, SENT);
    @(negedge clk);
    check("R7 trap one cycle", {127'b0, trap_o}, 128'd0);
  endtask

  task automatic t_facility();
    logic t, f; logic [127:0] v;
    do_reset();
    load(6'd16, SENT);
    load(6'd15, {SNAN, P2_75});
    run_op(6'd15, 6'd16, 1'b0, 1'b1, t, f);
    check("R9 fac pulse", {127'b0, f}, 128'd1);
    check("R9 no trap", {127'b0, t}, 128'd0);
    check("R9 sticky unchanged", {127'b0, sticky_snan_o}, 128'd0);
    peek(6'd16, v);
    check("R9 no write", v, SENT);
  endtask

  task automatic t_index();
    logic t, f; logic [127:0] v;
    load(6'd8, SENT);
    load(6'd40, {P2_75, M3_5});
    run_op(6'd40, 6'd2, 1'b1, 1'b0, t, f);
    peek(6'd2, v);
    check("R2 R11 high source index", v, {P2_0, M3_0});
    peek(6'd8, v);
    check("R2 low alias untouched", v, SENT);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_normal();
    t_small();
    t_edge();
    t_pass();
    t_snan_untrapped();
    t_snan_trapped();
    t_facility();
    t_index();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule